// File: doc/BRIEF.md
# Delayed Transaction Retry-Limit Monitor

This block sits beside the delayed transaction queue of a bus bridge and watches how often the bridge re-issues one queued delayed read or write on the target bus. Each re-issue arrives as an attempt strobe that carries the transaction's tag. The block counts attempts of the tag it is tracking and restarts the count whenever a different tag shows up or the tracked transaction completes.

When the count reaches the configured limit, the block gives up on the transaction. It pulses a discard strobe for one cycle so the queue drops the entry. It sets a sticky expiry flag that stays set until software clears it. It also raises a one-cycle system-error request, but only if the global error-report enable is set and the per-event mask for undelivered delayed writes is clear. The limit is a parameter: it defaults to 2^24 attempts and can be made small for verification. It must be at least 2.

Top module: `dly_retry_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `discard`, `serr_req` and `expired_flag` are all 0.
- R2: For LIMIT consecutive attempts of one tag, with no completion in between, `discard` is 0 after the first LIMIT-1 attempts. It is 1 for exactly the one cycle after the clock edge that samples the LIMIT-th attempt.
- R3: In that same cycle `serr_req` is 1 if `serr_en` was 1 and `dwnd_mask` was 0 at the expiring attempt. `serr_req` is never 1 without `discard`.
- R4: If `serr_en` is 0 or `dwnd_mask` is 1 at the expiring attempt, `serr_req` stays 0, and the discard and the flag still occur.
- R5: `expired_flag` becomes 1 together with the discard pulse, whatever the gating. It holds until `flag_clr` is sampled high. If an expiry and `flag_clr` happen in the same cycle, the flag is set.
- R6: An attempt whose tag differs from the tracked tag restarts the count: it counts as attempt 1 of the new tag.
- R7: `done_vld` drops tracking and zeroes the count. An attempt sampled in the same cycle as `done_vld` is not counted.
- R8: After an expiry nothing is tracked, so the next attempt, even one with the same tag, counts as attempt 1.
- R9: Cycles with `attempt_vld` low do not change the count, whatever `attempt_tag` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| attempt_vld | input | 1 | One target-bus attempt of a delayed transaction this cycle |
| attempt_tag | input | TAG_W | Identifies the queued transaction being attempted |
| done_vld | input | 1 | Tracked transaction completed or was cleared |
| serr_en | input | 1 | Global system-error report enable |
| dwnd_mask | input | 1 | Masks the error report for undelivered delayed writes |
| flag_clr | input | 1 | Software clear of the sticky expiry flag |
| discard | output | 1 | One-cycle request to drop the queued entry |
| serr_req | output | 1 | One-cycle system-error assertion request |
| expired_flag | output | 1 | Sticky flag recording a retry-limit expiry |

## Verification
The bench uses a limit of 4 and aims at the edges of the count. An off-by-one counter would discard on the third or fifth attempt instead of the fourth. A design that kept tracking after an expiry would discard again too early on the same tag. A design that ignored tag changes would expire on a mix of tags. A design that let an attempt beat a completion in the same cycle would count an attempt that should be dropped. Three cases test the gating and the flag: a design that folded the mask into the flag would lose the flag while the error report is masked, a design that let a clear beat a new expiry would drop a fresh event, and a design that ignored the mask or the enable would report the error anyway.

// File: rtl/dly_retry_guard.sv
module dly_retry_guard #(
  parameter int TAG_W = 8,
  parameter int LIMIT = 1 << 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             attempt_vld,
  input  logic [TAG_W-1:0] attempt_tag,
  input  logic             done_vld,
  input  logic             serr_en,
  input  logic             dwnd_mask,
  input  logic             flag_clr,
  output logic             discard,
  output logic             serr_req,
  output logic             expired_flag
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic             trk;
  logic [TAG_W-1:0] cur_tag;
  logic [CNT_W-1:0] cnt;

  // R6 / R8: a new tag, or nothing tracked, starts again at one
  wire             same = trk && (attempt_tag == cur_tag);
  wire [CNT_W-1:0] nxt  = same ? cnt + CNT_W'(1) : CNT_W'(1);
  wire             take = attempt_vld && !done_vld;   // R7, R9
  wire             hit  = take && (nxt == CNT_W'(LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trk          <= 1'b0;
      cur_tag      <= '0;
      cnt          <= '0;
      discard      <= 1'b0;
      serr_req     <= 1'b0;
      expired_flag <= 1'b0;
    end else begin
      discard  <= hit;
      serr_req <= hit && serr_en && !dwnd_mask;
      if (done_vld || hit) begin
        trk <= 1'b0;
        cnt <= '0;
      end else if (take) begin
        trk     <= 1'b1;
        cur_tag <= attempt_tag;
        cnt     <= nxt;
      end
      if (hit)           expired_flag <= 1'b1;
      else if (flag_clr) expired_flag <= 1'b0;
    end
  end

  p_cnt_below_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(LIMIT));
  p_discard_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    discard |=> !discard);
  p_serr_needs_discard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    serr_req |-> discard);
  p_serr_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    serr_req |-> $past(serr_en && !dwnd_mask));
  p_flag_with_discard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    discard |-> expired_flag);
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_flag && !flag_clr) |=> expired_flag);
  p_done_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld |=> (cnt == '0 && !trk));
endmodule

// File: tb/dly_retry_guard_tb.sv
module dly_retry_guard_tb;
  localparam int TAG_W = 4;
  localparam int LIMIT = 4;
  localparam int NV    = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic attempt_vld, done_vld, serr_en, dwnd_mask, flag_clr;
  logic [TAG_W-1:0] attempt_tag;
  logic discard, serr_req, expired_flag;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dly_retry_guard #(.TAG_W(TAG_W), .LIMIT(LIMIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .attempt_vld(attempt_vld), .attempt_tag(attempt_tag),
    .done_vld(done_vld), .serr_en(serr_en), .dwnd_mask(dwnd_mask), .flag_clr(flag_clr),
    .discard(discard), .serr_req(serr_req), .expired_flag(expired_flag));

  // fields: att tag[3:0] done en mask clr | exp discard serr flag
  function automatic logic [11:0] v(input logic a, input logic [3:0] t, input logic d,
      input logic e, input logic m, input logic c, input logic xd, input logic xs,
      input logic xf);
    return {a, t, d, e, m, c, xd, xs, xf};
  endfunction

  localparam logic [11:0] VEC [NV] = '{
    v(1,3,0,1,0,0, 0,0,0), v(1,3,0,1,0,0, 0,0,0), v(1,3,0,1,0,0, 0,0,0),
    v(1,3,0,1,0,0, 1,1,1),                          // R2 R3 fourth attempt expires
    v(0,3,0,1,0,0, 0,0,1),                          // R2 single pulse, R5 sticky
    v(0,0,0,1,0,1, 0,0,0),                          // R5 clear
    v(1,5,0,1,0,0, 0,0,0), v(1,5,0,1,0,0, 0,0,0),
    v(1,6,0,1,0,0, 0,0,0), v(1,6,0,1,0,0, 0,0,0),   // R6 new tag restarts
    v(1,6,0,1,0,0, 0,0,0),
    v(1,6,0,1,1,0, 1,0,1),                          // R4 masked, R5 flag set anyway
    v(0,0,0,1,0,1, 0,0,0),
    v(1,7,0,0,0,0, 0,0,0),
    v(1,7,1,0,0,0, 0,0,0),                          // R7 done wins over attempt
    v(1,7,0,1,0,0, 0,0,0), v(1,7,0,1,0,0, 0,0,0),
    v(0,7,1,1,0,0, 0,0,0),                          // R7 done clears
    v(1,7,0,1,0,0, 0,0,0), v(1,7,0,1,0,0, 0,0,0), v(1,7,0,1,0,0, 0,0,0),
    v(1,7,0,0,0,0, 1,0,1),                          // R4 enable off
    v(1,7,0,1,0,1, 0,0,0),                          // R8 restart after expiry, clear
    v(1,7,0,1,0,0, 0,0,0), v(1,7,0,1,0,0, 0,0,0),
    v(1,7,0,1,0,1, 1,1,1),                          // R5 set beats clear
    v(0,7,0,1,0,0, 0,0,1), v(0,7,0,1,0,0, 0,0,1),   // R9 idle with tag present
    v(1,7,0,1,0,0, 0,0,1), v(1,7,0,1,0,0, 0,0,1), v(1,7,0,1,0,0, 0,0,1),
    v(1,7,0,1,0,0, 1,1,1)                           // R9 count was not advanced
  };

  task automatic chk(input string req, input logic act, input logic exp, input int row);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s row %0d actual %b expected %b", req, row, act, exp);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; attempt_vld = 0; attempt_tag = '0; done_vld = 0;
    serr_en = 0; dwnd_mask = 0; flag_clr = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 discard", discard, 1'b0, -1);
    chk("R1 serr_req", serr_req, 1'b0, -1);
    chk("R1 expired_flag", expired_flag, 1'b0, -1);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 discard after release", discard, 1'b0, -1);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {attempt_vld, attempt_tag, done_vld, serr_en, dwnd_mask, flag_clr} = VEC[i][11:3];
      @(posedge clk); #1;
      chk("R2 discard", discard, VEC[i][2], i);
      chk("R3/R4 serr_req", serr_req, VEC[i][1], i);
      chk("R5 expired_flag", expired_flag, VEC[i][0], i);
    end
    // R2: the pulse ends the following cycle
    @(negedge clk);
    attempt_vld = 0; flag_clr = 0;
    @(posedge clk); #1;
    chk("R2 discard drops", discard, 1'b0, NV);
    chk("R5 flag holds", expired_flag, 1'b1, NV);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule